// File: doc/BRIEF.md
# Instruction Cache with Abortable Line Refill

This block is a direct-mapped instruction cache placed between a fetch unit and a simple memory bus. The fetch side hands in one byte address at a time over a valid/ready request channel. A hit returns the instruction word on the next cycle. A miss starts a refill state machine that reads the whole line from the bus, one word per acknowledge, and then answers the pending fetch. The tag, valid and data arrays, the hit/miss compare, the refill sequencing and the error path are all inside the block.

A bus error can arrive on any beat of a refill. When it does, the cache drops the rest of the burst at once and returns to idle. It answers the pending fetch with an error flag in place of an instruction. The line's valid bit is dropped on the first word written. A line that was partly overwritten therefore never hits, and a line that was not touched keeps its old contents.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the cache is idle, so it stays low during a lookup, a refill and the response cycle. The response is a one-cycle strobe on `rsp_valid` with no ready signal, and the fetch side must take it in that cycle. On the bus side, `mem_req` and `mem_addr` are held steady until the memory answers with `mem_ack` or `mem_err`. If both arrive in the same cycle, the error wins.

Top module: `icache_refill`

## Requirements
- R1: After reset every line is invalid, `mem_req` and `rsp_valid` are low and `req_ready` is high, so the first fetch to any address misses.
- R2: A fetch that hits raises `rsp_valid` with the stored word and `rsp_err` low in the cycle after the request is accepted, with no bus activity.
- R3: A fetch that misses keeps `rsp_valid` low and `req_ready` low from acceptance until the cycle after the refill ends or aborts.
- R4: A refill starts one cycle after the lookup. It requests words in ascending order from the line-aligned address, with address step 4 (bits [1:0] zero, bits [4:2] the word number for an 8-word line). Each beat holds `mem_req` and `mem_addr` until `mem_ack` or `mem_err`, and the next beat's address appears in the cycle after an acknowledge.
- R5: The target line's valid bit is cleared when the first refill word is written, not at the end of the refill.
- R6: After the last word is acknowledged without error, the line becomes valid with its new tag. In the next cycle `rsp_valid` is high with the requested word, and later fetches to that line hit.
- R7: A bus error on any beat after the first leaves the line invalid, so the next fetch to either the old or the new address of that line misses.
- R8: A bus error on the first beat changes nothing in the line: its old tag, data and valid bit stay in place, and a later fetch to the old address hits with the old word.
- R9: On a bus error `mem_req` drops in the next cycle, no further beat is requested, and `req_ready` returns high one cycle after that.
- R10: On a bus error the cycle after the error carries `rsp_valid` and `rsp_err` both high for the faulting fetch, with `rsp_data` zero.
- R11: After an abort, a new fetch to the same address starts a fresh refill from the first word of the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Cache can take a request (idle) |
| req_addr | input | ADDR_W | Fetch byte address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Instruction word (zero on error) |
| rsp_err | output | 1 | Bus-error exception for the fetch |
| mem_req | output | 1 | Bus beat request, held until ack or error |
| mem_addr | output | ADDR_W | Bus word address of the current beat |
| mem_ack | input | 1 | Bus beat completed, data valid |
| mem_err | input | 1 | Bus beat failed |
| mem_rdata | input | DATA_W | Bus read data |

## Verification
The results fall due at fixed cycles. A hit answers in the cycle after the accepting edge. A miss issues its first beat one cycle after the lookup, each later beat one cycle after the previous acknowledge, and its response one cycle after the last acknowledge or the error, with `req_ready` back one cycle after that. The bench counts those edges as it drives the request and the bus, and samples one time unit after each rising edge. It compares `rsp_valid`, `rsp_data`, `rsp_err`, `mem_req`, `mem_addr` and `req_ready` in every cycle against a behavioural model of the line contents. Bus latency varies between zero and several wait cycles, so the hold rule is checked on stalled beats.

// File: rtl/icr_pkg.sv
package icr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_REFILL = 2'd2,
    ST_RESP   = 2'd3
  } icr_state_e;
endpackage

// File: rtl/icr_tag_store.sv
module icr_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             inval_en,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[wr_idx] <= 1'b1;
    end else if (inval_en) begin
      valid_q[wr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  // R5: the first written word knocks the line out
  assert_inval_first_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_en && !fill_en) |=> !valid_q[$past(wr_idx)]);

  // R6: a completed fill leaves the line valid with its tag
  assert_fill_sets_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/icr_data_store.sv
module icr_data_store #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) word_q[waddr] <= wdata;
  end

  assign rdata = word_q[raddr];

  // R4: every acknowledged beat lands in the array
  assert_beat_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (word_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/icr_refill_fsm.sv
module icr_refill_fsm
  import icr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BYTE_OFF   = 2,
  parameter int LINE_WORDS = 8,
  localparam int OFF_W = $clog2(LINE_WORDS),
  localparam int WA_W  = ADDR_W - BYTE_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WA_W-1:0]   req_word,
  output logic [WA_W-1:0]   lk_word,
  input  logic              hit,
  output logic [OFF_W-1:0]  beat,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              word_we,
  output logic              inval_en,
  output logic              fill_en,
  output logic              rsp_valid,
  output logic              rsp_err
);
  localparam logic [OFF_W-1:0]  LAST_BEAT = OFF_W'(LINE_WORDS - 1);
  localparam logic [ADDR_W-1:0] BEAT_INC  = ADDR_W'(2 ** BYTE_OFF);

  icr_state_e       state_q, state_d;
  logic [OFF_W-1:0] beat_q, beat_d;
  logic             err_q, err_d;
  logic [WA_W-1:0]  lk_q, lk_d;

  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    err_d     = err_q;
    lk_d      = lk_q;
    req_ready = 1'b0;
    mem_req   = 1'b0;
    word_we   = 1'b0;
    inval_en  = 1'b0;
    fill_en   = 1'b0;
    rsp_valid = 1'b0;
    rsp_err   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          lk_d    = req_word;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          rsp_valid = 1'b1;
          state_d   = ST_IDLE;
        end else begin
          beat_d  = '0;
          err_d   = 1'b0;
          state_d = ST_REFILL;
        end
      end
      ST_REFILL: begin
        mem_req = 1'b1;
        if (mem_err) begin
          err_d   = 1'b1;
          state_d = ST_RESP;
        end else if (mem_ack) begin
          word_we  = 1'b1;
          inval_en = (beat_q == '0);
          if (beat_q == LAST_BEAT) begin
            fill_en = 1'b1;
            state_d = ST_RESP;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      ST_RESP: begin
        rsp_valid = 1'b1;
        rsp_err   = err_q;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      err_q   <= 1'b0;
      lk_q    <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      err_q   <= err_d;
      lk_q    <= lk_d;
    end
  end

  assign lk_word  = lk_q;
  assign beat     = beat_q;
  assign mem_addr = {lk_q[WA_W-1:OFF_W], beat_q, {BYTE_OFF{1'b0}}};

  // R4: a stalled beat keeps its request and address
  assert_beat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr)));

  // R4: an acknowledged middle beat moves to the next word
  assert_beat_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_err && beat_q != LAST_BEAT)
      |=> (mem_req && mem_addr == $past(mem_addr) + BEAT_INC));

  // R9, R10: an error ends the burst and reports the fault
  assert_err_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_err) |=> (!mem_req && rsp_valid && rsp_err));

  // R9: after the fault strobe the cache is idle again
  assert_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |=> (req_ready && !mem_req));
endmodule

// File: rtl/icache_refill.sv
module icache_refill #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int LINES      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BYTE_OFF = $clog2(DATA_W / 8);
  localparam int OFF_W    = $clog2(LINE_WORDS);
  localparam int IDX_W    = $clog2(LINES);
  localparam int WA_W     = ADDR_W - BYTE_OFF;
  localparam int TAG_W    = WA_W - OFF_W - IDX_W;
  localparam int DEPTH    = LINES * LINE_WORDS;

  logic [BYTE_OFF-1:0] unused_byte_bits;
  logic [WA_W-1:0]     lk_word;
  logic [IDX_W-1:0]    lk_idx;
  logic [TAG_W-1:0]    lk_tag;
  logic [OFF_W-1:0]    lk_off;
  logic [OFF_W-1:0]    beat;
  logic                line_valid;
  logic [TAG_W-1:0]    line_tag;
  logic                hit;
  logic                word_we, inval_en, fill_en;
  logic                rsp_err_i;
  logic [DATA_W-1:0]   rd_word;

  assign unused_byte_bits = req_addr[BYTE_OFF-1:0];

  assign lk_off = lk_word[OFF_W-1:0];
  assign lk_idx = lk_word[OFF_W +: IDX_W];
  assign lk_tag = lk_word[WA_W-1 -: TAG_W];
  assign hit    = line_valid && (line_tag == lk_tag);

  icr_refill_fsm #(
    .ADDR_W(ADDR_W), .BYTE_OFF(BYTE_OFF), .LINE_WORDS(LINE_WORDS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_addr[ADDR_W-1:BYTE_OFF]), .lk_word(lk_word),
    .hit(hit), .beat(beat),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_err(mem_err),
    .word_we(word_we), .inval_en(inval_en), .fill_en(fill_en),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err_i)
  );

  icr_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_valid(line_valid), .rd_tag(line_tag),
    .wr_idx(lk_idx), .inval_en(inval_en), .fill_en(fill_en), .wr_tag(lk_tag)
  );

  icr_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n),
    .we(word_we), .waddr({lk_idx, beat}), .wdata(mem_rdata),
    .raddr({lk_idx, lk_off}), .rdata(rd_word)
  );

  assign rsp_err  = rsp_err_i;
  assign rsp_data = rsp_err_i ? '0 : rd_word;
endmodule

// File: tb/icache_refill_tb.sv
module icache_refill_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 16;
  localparam int WORDS      = 8;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_err;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] gen = 32'h1357_0000;

  // behavioural picture of the cache contents
  bit          m_valid [LINES];
  logic [31:0] m_tag   [LINES];
  logic [31:0] m_data  [LINES][WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_refill u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] memfn(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ gen;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one fetch; err_beat < 0 means the bus never errs; lat = wait cycles per beat
  task automatic fetch(logic [31:0] addr, int err_beat, int lat, string tag);
    int idx = int'((addr >> 5) % LINES);
    logic [31:0] ltag = addr >> 9;
    int off = int'((addr >> 2) % WORDS);
    logic [31:0] base = addr & ~32'h1F;
    bit hit = m_valid[idx] && (m_tag[idx] == ltag);
    bit aborted = 1'b0;
    chk(tag, "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_addr  = addr;
    tick();
    req_valid = 1'b0;
    if (hit) begin
      chk({tag, " R2"}, "hit rsp_valid", 32'(rsp_valid), 32'd1);
      chk({tag, " R2"}, "hit data", rsp_data, m_data[idx][off]);
      chk({tag, " R2"}, "hit rsp_err", 32'(rsp_err), 32'd0);
      chk({tag, " R2"}, "hit no bus", 32'(mem_req), 32'd0);
      tick();
    end else begin
      chk({tag, " R3"}, "lookup rsp_valid", 32'(rsp_valid), 32'd0);
      tick();
      for (int b = 0; b < WORDS && !aborted; b++) begin
        for (int w = 0; w < lat; w++) begin
          chk({tag, " R4"}, "stall mem_req", 32'(mem_req), 32'd1);
          chk({tag, " R4"}, "stall mem_addr", mem_addr, base + 32'(4 * b));
          chk({tag, " R3"}, "stall rsp/ready", {30'd0, rsp_valid, req_ready}, 32'd0);
          tick();
        end
        chk({tag, " R4 R11"}, "beat mem_req", 32'(mem_req), 32'd1);
        chk({tag, " R4 R11"}, "beat mem_addr", mem_addr, base + 32'(4 * b));
        chk({tag, " R3"}, "beat rsp/ready", {30'd0, rsp_valid, req_ready}, 32'd0);
        if (b == err_beat) begin
          mem_err = 1'b1;
          aborted = 1'b1;
        end else begin
          mem_ack   = 1'b1;
          mem_rdata = memfn(mem_addr);
          if (b == 0) m_valid[idx] = 1'b0;
          m_data[idx][b] = mem_rdata;
        end
        tick();
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end
      if (aborted) begin
        chk({tag, " R9"}, "bus dropped", 32'(mem_req), 32'd0);
        chk({tag, " R10"}, "err strobe", {30'd0, rsp_valid, rsp_err}, 32'd3);
        chk({tag, " R10"}, "err data", rsp_data, 32'd0);
      end else begin
        m_valid[idx] = 1'b1;
        m_tag[idx]   = ltag;
        chk({tag, " R6"}, "fill strobe", {30'd0, rsp_valid, rsp_err}, 32'd2);
        chk({tag, " R6"}, "fill data", rsp_data, m_data[idx][off]);
        chk({tag, " R6"}, "bus idle", 32'(mem_req), 32'd0);
      end
      tick();
    end
    chk({tag, " R9"}, "ready after fetch", 32'(req_ready), 32'd1);
    chk({tag, " R3"}, "no extra strobe", 32'(rsp_valid), 32'd0);
    chk({tag, " R9"}, "no stray beat", 32'(mem_req), 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) m_valid[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset req_ready", 32'(req_ready), 32'd1);
    chk("R1", "reset mem_req", 32'(mem_req), 32'd0);
    chk("R1", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    tick();

    // cold miss, then hits in the same line
    fetch(32'h0000_0100, -1, 0, "R1");
    fetch(32'h0000_0104, -1, 0, "R2");
    fetch(32'h0000_011C, -1, 0, "R2");
    fetch(32'h0000_2108, -1, 2, "R3 R4");

    // error after some words: line must stay invalid
    gen = 32'h2468_0000;
    fetch(32'h0000_0340, -1, 1, "R5");
    fetch(32'h0000_0540, 3, 1, "R7 R9");
    fetch(32'h0000_0348, -1, 0, "R5 R7");

    // error on the very first beat: old line survives
    gen = 32'h0000_0005;
    fetch(32'h0000_0480, -1, 0, "R8");
    gen = 32'h0000_0006;
    fetch(32'h0000_0880, 0, 3, "R8 R10");
    fetch(32'h0000_0484, -1, 0, "R8");

    // abort then retry the same address from word 0
    fetch(32'h0000_06A4, 5, 0, "R11");
    fetch(32'h0000_06A4, -1, 1, "R11");
    fetch(32'h0000_06A8, -1, 0, "R11");

    // error on the last beat still leaves the line invalid
    fetch(32'h0000_07E0, -1, 0, "R6");
    fetch(32'h0000_0FE4, 7, 0, "R7");
    fetch(32'h0000_07E0, -1, 0, "R7");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule